// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block makes the serial clock for an I2C master bit engine, along with the timing strobes the engine needs to handle SDA. It divides the core clock by a programmable period. Each period has a low half followed by a high half. Two other points in the period are placed by a packed delay word. The first is a one-cycle drive strobe, a set number of core clocks after SCL falls, which tells the engine to present its next SDA bit. The second is a one-cycle sample strobe, a set number of core clocks after SCL rises, which tells the engine to capture SDA.

A one-cycle period tick marks the first core clock of every SCL period. The period and delay inputs are captured only at a period boundary. Software or a controller can therefore change them at any time without creating a shortened pulse. When the run input is low, SCL is released high and the timing restarts from the beginning of a low phase.

Top module: `i2c_scl_timer`

## Requirements
- R1: Bit 0 of `divider` is ignored. An odd value gives the same waveform as the even value one below it.
- R2: An effective period below 2 (divider value 0 or 1) is treated as 2 core clocks.
- R3: `delays[31:16]` is the fall-to-drive delay and `delays[15:0]` is the rise-to-sample delay, both in core clocks.
- R4: `drive_stb` is high for exactly one core clock per period. That clock is the one where the count since SCL fell equals the fall delay. The first low cycle counts as 0.
- R5: `sample_stb` is high for exactly one core clock per period. That clock is the one where the count since SCL rose equals the rise delay. The first high cycle counts as 0.
- R6: A delay larger than half the period is clamped to half. At half, the drive strobe lands on the first high cycle. The sample strobe lands on the first low cycle of the next period, and is not issued after the last period before run drops.
- R7: A programmed delay of 0 behaves as a delay of 1.
- R8: With run high, SCL is low for the first half-period cycles of each period and high for the rest. The first cycle after run rises is a low cycle.
- R9: `period_tick` is high exactly in the first cycle of each SCL period.
- R10: While run is low, SCL is 1 and all strobes and the tick are 0. A later run restarts from the first low cycle.
- R11: The divider and delay values are captured at the start of each period. A change in the middle of a period takes effect from the next period.
- R12: During reset SCL is 1 and `drive_stb`, `sample_stb`, `period_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables SCL generation |
| divider | input | DIV_W (16) | Core clocks per SCL period; bit 0 ignored |
| delays | input | 2*DIV_W (32) | Fall-to-drive delay in upper half, rise-to-sample delay in lower half |
| scl | output | 1 | Generated serial clock level |
| drive_stb | output | 1 | One-cycle SDA drive point |
| sample_stb | output | 1 | One-cycle SDA sample point |
| period_tick | output | 1 | First cycle of each SCL period |

## Verification
run is raised on a falling clock edge. The next rising edge starts the first period, so the cycle that follows it is count 0: SCL is low, the tick is high, and from then on every output is a function of the cycle count alone. The scoreboard builds one expected entry per core clock from the requirements. It pops one entry per cycle, 1 ns after each rising edge, starting from the first rising edge after the stimulus. Idle entries after run falls follow the same rule, so no output is ever sampled in the cycle it changes. A change in the middle of a period is applied at a falling edge well before the wrap, and the expected sequence switches to the new values from the next count 0.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

   // widest field a timing value may occupy
   localparam int unsigned SCLG_MAX_W = 32;

   // delay normalisation: zero -> one, above limit -> limit
   function automatic logic [SCLG_MAX_W-1:0] sclg_sat(
      input logic [SCLG_MAX_W-1:0] v,
      input logic [SCLG_MAX_W-1:0] lim);
      if (v == '0)
         return SCLG_MAX_W'(1);
      else if (v > lim)
         return lim;
      else
         return v;
   endfunction

endpackage

// File: rtl/sclg_cfg.sv
module sclg_cfg
   import i2c_sclgen_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [DW-1:0]   div_in,
   input  logic [2*DW-1:0] dly_in,
   output logic [DW-1:0]   half_q,
   output logic [DW-1:0]   fall_q,
   output logic [DW-1:0]   rise_q
);
   localparam logic [DW-1:0] ONE = DW'(1);

   logic [DW-1:0] half_d;
   logic [DW-1:0] del_d [2];

   // bit 0 dropped; period floor of two core clocks
   assign half_d = (div_in[DW-1:1] == '0) ? ONE : {1'b0, div_in[DW-1:1]};

   // index 0: rise-to-sample (low field), index 1: fall-to-drive (high field)
   for (genvar i = 0; i < 2; i++) begin : g_del
      logic [DW-1:0] raw;
      assign raw      = dly_in[i*DW +: DW];
      assign del_d[i] = DW'(sclg_sat(SCLG_MAX_W'(raw), SCLG_MAX_W'(half_d)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= ONE;
         fall_q <= ONE;
         rise_q <= ONE;
      end else if (load) begin
         half_q <= half_d;
         fall_q <= del_d[1];
         rise_q <= del_d[0];
      end
   end

   // R6
   fall_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_q != '0) && (fall_q <= half_q));

endmodule

// File: rtl/sclg_phase.sv
module sclg_phase #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [DW-1:0] half,
   input  logic [DW-1:0] rise,
   output logic [DW-1:0] cnt_q,
   output logic          active_q,
   output logic          late_q,
   output logic          load
);
   logic [DW-1:0] per_m1;
   logic          last;

   assign per_m1 = {half[DW-2:0], 1'b0} - DW'(1);
   assign last   = active_q && (cnt_q == per_m1);
   // capture new settings while idle and on each wrap
   assign load   = !active_q || last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         late_q   <= 1'b0;
      end else if (!run) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         late_q   <= 1'b0;
      end else begin
         active_q <= 1'b1;
         late_q   <= last && (rise == half);
         if (!active_q || last)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + DW'(1);
      end
   end

   // R10
   run_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!active_q && cnt_q == '0 && !late_q));

endmodule

// File: rtl/sclg_strobe.sv
module sclg_strobe #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          late,
   input  logic [DW-1:0] cnt,
   input  logic [DW-1:0] half,
   input  logic [DW-1:0] fall,
   input  logic [DW-1:0] rise,
   output logic          scl,
   output logic          drive,
   output logic          sample,
   output logic          tick
);
   logic [DW-1:0] samp_pt;

   assign samp_pt = half + rise;
   assign scl     = !active || (cnt >= half);
   assign tick    = active && (cnt == '0);
   assign drive   = active && (cnt == fall);
   assign sample  = active && (((rise < half) && (cnt == samp_pt)) || late);

   // R8
   scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl) |-> tick);

   // R9
   tick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> !scl);

   // R4
   drive_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive |=> !drive);

   // R6
   drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (cnt != '0 && cnt <= half));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
   parameter int unsigned DIV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [DIV_W-1:0]   divider,
   input  logic [2*DIV_W-1:0] delays,
   output logic               scl,
   output logic               drive_stb,
   output logic               sample_stb,
   output logic               period_tick
);
   if (DIV_W < 2 || DIV_W > 31) begin : g_bad_width
      $error("i2c_scl_timer: DIV_W must lie in 2..31");
   end

   logic [DIV_W-1:0] half_q, fall_q, rise_q, cnt_q;
   logic             active_q, late_q, load;

   sclg_cfg #(.DW(DIV_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .div_in (divider),
      .dly_in (delays),
      .half_q (half_q),
      .fall_q (fall_q),
      .rise_q (rise_q)
   );

   sclg_phase #(.DW(DIV_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .half     (half_q),
      .rise     (rise_q),
      .cnt_q    (cnt_q),
      .active_q (active_q),
      .late_q   (late_q),
      .load     (load)
   );

   sclg_strobe #(.DW(DIV_W)) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active_q),
      .late   (late_q),
      .cnt    (cnt_q),
      .half   (half_q),
      .fall   (fall_q),
      .rise   (rise_q),
      .scl    (scl),
      .drive  (drive_stb),
      .sample (sample_stb),
      .tick   (period_tick)
   );

endmodule

// File: tb/i2c_scl_timer_test.sv
module i2c_scl_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [15:0] divider = 16'd8;
   logic [31:0] delays = 32'd0;
   logic        scl, drive_stb, sample_stb, period_tick;

   int checks = 0;
   int errors = 0;

   typedef struct {
      bit scl;
      bit drv;
      bit smp;
      bit tck;
      int req;
   } exp_t;

   exp_t q[$];
   bit   carry_late;

   always #2 clk = ~clk;  // 250 MHz

   i2c_scl_timer uut (
      .clk(clk), .rst_n(rst_n), .run(run), .divider(divider), .delays(delays),
      .scl(scl), .drive_stb(drive_stb), .sample_stb(sample_stb),
      .period_tick(period_tick)
   );

   function automatic string rname(input int r);
      case (r)
         1: return "R1";   2: return "R2";   3: return "R3";
         4: return "R4";   5: return "R5";   6: return "R6";
         7: return "R7";   8: return "R8";   9: return "R9";
         10: return "R10"; 11: return "R11"; 12: return "R12";
         default: return "R?";
      endcase
   endfunction

   task automatic compare(input exp_t e);
      checks++;
      if (scl !== e.scl || drive_stb !== e.drv || sample_stb !== e.smp ||
          period_tick !== e.tck) begin
         errors++;
         $display("FAIL %s: got scl=%b drv=%b smp=%b tck=%b expected scl=%b drv=%b smp=%b tck=%b",
                  rname(e.req), scl, drive_stb, sample_stb, period_tick,
                  e.scl, e.drv, e.smp, e.tck);
      end
   endtask

   // monitor: one entry per core clock, 1 ns after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) compare(q.pop_front());
      end
   end

   // expected-model generator built from the requirements
   task automatic push_periods(input int div, input int fall, input int rise,
                               input int n, input int req);
      int e, h, f, r;
      e = div & ~1;            // R1
      if (e < 2) e = 2;        // R2
      h = e / 2;
      f = (fall == 0) ? 1 : (fall > h ? h : fall);   // R6 R7
      r = (rise == 0) ? 1 : (rise > h ? h : rise);
      for (int k = 0; k < n; k++) begin
         for (int p = 0; p < e; p++) begin
            exp_t it;
            it.scl = (p >= h);                       // R8
            it.tck = (p == 0);                       // R9
            it.drv = (p == f);                       // R4
            it.smp = ((r < h) && (p == h + r)) || ((p == 0) && carry_late);  // R5 R6
            it.req = req;
            q.push_back(it);
         end
         carry_late = (r == h);
      end
   endtask

   task automatic wait_empty();
      while (q.size() > 0) @(negedge clk);
   endtask

   task automatic stop_run(input int req);
      wait_empty();
      @(negedge clk);
      run = 1'b0;
      for (int i = 0; i < 4; i++) begin
         exp_t it;
         it.scl = 1'b1; it.drv = 1'b0; it.smp = 1'b0; it.tck = 1'b0; it.req = req;
         q.push_back(it);
      end
      wait_empty();
   endtask

   task automatic start_case(input int div, input int fall, input int rise,
                             input int n, input int req);
      wait_empty();
      @(negedge clk);
      divider    = 16'(div);
      delays     = {16'(fall), 16'(rise)};   // R3 field order
      run        = 1'b1;
      carry_late = 1'b0;
      push_periods(div, fall, rise, n, req);
   endtask

   initial begin
      exp_t rs;
      // R12 reset state
      #7;
      rs.scl = 1'b1; rs.drv = 1'b0; rs.smp = 1'b0; rs.tck = 1'b0; rs.req = 12;
      compare(rs);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 idle after reset
      rs.req = 10;
      @(negedge clk);
      compare(rs);

      // R8 R9 R4 R5: basic period 8, drive 1, sample 2
      start_case(8, 1, 2, 3, 8);
      stop_run(10);
      // R1 odd divider acts as 8
      start_case(9, 1, 2, 2, 1);
      stop_run(10);
      // R2 R7 tiny divider with zero delays (sample wraps onto next low cycle)
      start_case(1, 0, 0, 4, 2);
      stop_run(10);
      // R6 clamp of oversize delays
      start_case(12, 32, 32, 3, 6);
      stop_run(10);
      // R3 distinct fields
      start_case(20, 3, 7, 2, 3);
      stop_run(10);
      // R5 sample late in high half
      start_case(14, 6, 4, 2, 5);
      stop_run(10);

      // R11 mid-period change: 16 then 8
      start_case(16, 2, 3, 1, 11);
      push_periods(8, 2, 3, 2, 11);
      repeat (3) @(negedge clk);
      divider = 16'd8;
      stop_run(11);

      // R10 restart begins at low phase
      start_case(6, 1, 1, 2, 10);
      stop_run(10);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule